// File: doc/BRIEF.md
# Four-Format Serial Transmitter

This block is the sending half of a full-duplex serial port. A one-cycle write strobe hands it a byte. If no frame is in flight, the byte is accepted and a frame goes out at once on the data line. The format is chosen by a two-bit mode input, which is sampled at the write. There are four formats:

- a synchronous 8-bit shift with its own shift clock,
- an 8-bit asynchronous frame,
- two 9-bit asynchronous frames, where the ninth bit is taken from a control input.

A sticky completion flag rises when the frame has finished. Only an explicit clear input lowers it. Bit timing comes from tick pulses that are generated outside the block. The receiver shares nothing with this block.

Internally one shift register and one bit counter serve every format. A controller steps through these states:

- `ST_IDLE`
- `ST_SYNC_SET` (shift clock high, data valid)
- `ST_SYNC_CLK` (shift clock low)
- `ST_START`
- `ST_DATA`
- `ST_NINTH`
- `ST_STOP`

These are the transitions:

- IDLE to SYNC_SET on an accepted write in mode 0.
- IDLE to START on an accepted write in any other mode.
- SYNC_SET to SYNC_CLK on a bit tick.
- SYNC_CLK back to SYNC_SET on a bit tick when bits remain, shifting the register.
- SYNC_CLK to IDLE on a bit tick after the eighth bit.
- START to DATA on a bit tick.
- DATA to DATA on a bit tick while bits remain, shifting the register.
- DATA to NINTH on the tick ending the eighth data bit in a 9-bit mode.
- DATA to STOP on that same tick in mode 1.
- NINTH to STOP on a bit tick.
- STOP to IDLE on a bit tick.

Each transition into IDLE sets the completion flag.

Top module: `sertx_top`

## Requirements
- R1: Out of reset and whenever no frame is in flight, `txd` is 1, `shclk` is 1 and `done_flag` is 0 until first set.
- R2: In mode 1 (`mode_sel`=01), the line carries a 0 start bit, then eight data bits least significant first, then a 1 stop bit. Each bit ends on a `tick_var` pulse. The start bit appears in the cycle after the accepted write.
- R3: In modes 2 (10) and 3 (11), a ninth bit equal to `ninth_bit` goes between the eighth data bit and the stop bit.
- R4: In mode 2, each `tick_fixed` pulse ends a bit when `dbl_rate`=1. When `dbl_rate`=0, every second `tick_fixed` pulse ends a bit, counted from the accepted write.
- R5: In mode 0 (00), each data bit sits on `txd` least significant first. Each bit lasts for two `tick_sync` pulses: `shclk` stays high until the first pulse and low until the second. `ninth_bit` has no effect.
- R6: `done_flag` rises in the cycle after the tick that ends the frame. In mode 0 that tick ends the low half of the eighth bit. In the other modes it ends the stop bit.
- R7: `done_flag` stays at 1 until `done_clr` is high at a clock edge. When the frame ends in the same cycle as `done_clr`, the flag is 1 afterwards.
- R8: A write strobe while a frame is in flight is ignored, and that frame completes unchanged.
- R9: `mode_sel` and `ninth_bit` are captured at the accepted write. Changing them during the frame has no effect on it.
- R10: Mode 1 and mode 3 use only `tick_var`, mode 0 only `tick_sync`, and mode 2 only `tick_fixed`. Pulses on the other tick inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Frame format: 00 sync shift, 01 8-bit async, 10 9-bit fixed rate, 11 9-bit variable rate |
| ninth_bit | input | 1 | Ninth bit value for the 9-bit formats |
| wr_data | input | 8 | Byte to send |
| wr_stb | input | 1 | One-cycle write strobe that starts a frame |
| tick_sync | input | 1 | Half-bit tick for mode 0 |
| tick_var | input | 1 | Bit tick for modes 1 and 3 |
| tick_fixed | input | 1 | Base tick for mode 2 |
| dbl_rate | input | 1 | Mode 2 rate select: 1 uses every base tick, 0 every second one |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial data line, idles high |
| shclk | output | 1 | Mode 0 shift clock, idles high |
| done_flag | output | 1 | Sticky end-of-frame flag |

## Verification
Two things can fall in the same cycle: the frame-end tick that sets `done_flag`, and a `done_clr` from software. The bench provokes this by watching its own model. When one bit is left and the model predicts that the next edge carries a bit tick, the bench raises `done_clr` for that edge. It then expects the flag to remain 1. A second pairing is a write strobe landing in the middle of a frame, together with changes to the mode and ninth-bit inputs. It is judged by comparing the line against the model on every clock and by checking that the line stays idle afterwards.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        FM_SYNC       = 2'd0,
        FM_ASYNC8     = 2'd1,
        FM_ASYNC9_FIX = 2'd2,
        FM_ASYNC9_VAR = 2'd3
    } frame_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SYNC_SET = 3'd1,
        ST_SYNC_CLK = 3'd2,
        ST_START    = 3'd3,
        ST_DATA     = 3'd4,
        ST_NINTH    = 3'd5,
        ST_STOP     = 3'd6
    } tx_state_e;

    // The two 9-bit formats share the upper mode bit.
    function automatic logic has_ninth(frame_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/sertx_rate.sv
module sertx_rate
    import sertx_pkg::*;
#(
    parameter int SLOW_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  frame_mode_e mode,
    input  logic        tick_sync,
    input  logic        tick_var,
    input  logic        tick_fixed,
    input  logic        dbl_rate,
    output logic        bit_tick
);
    localparam int DW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

    logic [DW-1:0] div_q;
    logic          fixed_tick;

    // Divider phase restarts with each frame so the first slow bit is
    // exactly SLOW_DIV base ticks long.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (tick_fixed) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign fixed_tick = tick_fixed && (dbl_rate || (div_q == DIV_LAST));

    always_comb begin
        case (mode)
            FM_SYNC:       bit_tick = tick_sync;
            FM_ASYNC9_FIX: bit_tick = fixed_tick;
            default:       bit_tick = tick_var;
        endcase
    end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              line_bit,
    output logic              last
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);

    logic [DATA_W-1:0] sr_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '1;
            cnt_q <= '0;
        end else if (load) begin
            sr_q  <= din;
            cnt_q <= '0;
        end else if (shift) begin
            sr_q  <= {1'b1, sr_q[DATA_W-1:1]};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign line_bit = sr_q[0];
    assign last     = (cnt_q == LAST_IDX);

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  frame_mode_e mode_in,
    input  logic        ninth_in,
    input  logic        bit_tick,
    input  logic        last,
    input  logic        line_bit,
    input  logic        done_clr,
    output logic        load,
    output logic        shift,
    output logic        busy,
    output frame_mode_e mode_q,
    output logic        txd,
    output logic        shclk,
    output logic        done_flag
);
    tx_state_e state_q, state_d;
    logic      ninth_q;
    logic      set_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame attributes captured at the accepted write only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= FM_ASYNC8;
            ninth_q <= 1'b1;
        end else if (load) begin
            mode_q  <= mode_in;
            ninth_q <= ninth_in;
        end
    end

    // Completion flag: a frame end wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (set_done) begin
            done_flag <= 1'b1;
        end else if (done_clr) begin
            done_flag <= 1'b0;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        shift    = 1'b0;
        set_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_stb) begin
                    load    = 1'b1;
                    state_d = (mode_in == FM_SYNC) ? ST_SYNC_SET : ST_START;
                end
            end
            ST_SYNC_SET: begin
                if (bit_tick) begin
                    state_d = ST_SYNC_CLK;
                end
            end
            ST_SYNC_CLK: begin
                if (bit_tick) begin
                    if (last) begin
                        state_d  = ST_IDLE;
                        set_done = 1'b1;
                    end else begin
                        shift   = 1'b1;
                        state_d = ST_SYNC_SET;
                    end
                end
            end
            ST_START: begin
                if (bit_tick) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_tick) begin
                    if (last) begin
                        state_d = has_ninth(mode_q) ? ST_NINTH : ST_STOP;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            ST_NINTH: begin
                if (bit_tick) begin
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (bit_tick) begin
                    state_d  = ST_IDLE;
                    set_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Line outputs
    always_comb begin
        txd   = 1'b1;
        shclk = 1'b1;
        unique case (state_q)
            ST_SYNC_SET: txd = line_bit;
            ST_SYNC_CLK: begin
                txd   = line_bit;
                shclk = 1'b0;
            end
            ST_START:    txd = 1'b0;
            ST_DATA:     txd = line_bit;
            ST_NINTH:    txd = ninth_q;
            default:     txd = 1'b1;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SLOW_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              ninth_bit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_stb,
    input  logic              tick_sync,
    input  logic              tick_var,
    input  logic              tick_fixed,
    input  logic              dbl_rate,
    input  logic              done_clr,
    output logic              txd,
    output logic              shclk,
    output logic              done_flag
);
    frame_mode_e mode_q;
    logic        load;
    logic        shift;
    logic        busy;
    logic        bit_tick;
    logic        line_bit;
    logic        last;

    sertx_rate #(.SLOW_DIV(SLOW_DIV)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (load),
        .mode       (mode_q),
        .tick_sync  (tick_sync),
        .tick_var   (tick_var),
        .tick_fixed (tick_fixed),
        .dbl_rate   (dbl_rate),
        .bit_tick   (bit_tick)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .din      (wr_data),
        .line_bit (line_bit),
        .last     (last)
    );

    sertx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .mode_in   (frame_mode_e'(mode_sel)),
        .ninth_in  (ninth_bit),
        .bit_tick  (bit_tick),
        .last      (last),
        .line_bit  (line_bit),
        .done_clr  (done_clr),
        .load      (load),
        .shift     (shift),
        .busy      (busy),
        .mode_q    (mode_q),
        .txd       (txd),
        .shclk     (shclk),
        .done_flag (done_flag)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [1:0] mode_q,
    input logic       txd,
    input logic       shclk,
    input logic       done_flag,
    input logic       done_clr
);
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && shclk));

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && mode_q != 2'd0) |-> !txd);

    a_r5_clock_only_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !shclk |-> (busy && mode_q == 2'd0));

    a_r6_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(busy) && !busy));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);

    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));

endmodule

bind sertx_top sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mode_q    (mode_q),
    .txd       (txd),
    .shclk     (shclk),
    .done_flag (done_flag),
    .done_clr  (done_clr)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    localparam int CLK_NS = 10;
    localparam int P_SYNC = 3;
    localparam int P_VAR  = 5;
    localparam int P_FIX  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd1;
    logic       ninth_bit = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_stb = 1'b0;
    logic       tick_sync = 1'b0;
    logic       tick_var = 1'b0;
    logic       tick_fixed = 1'b0;
    logic       dbl_rate = 1'b0;
    logic       done_clr = 1'b0;
    logic       txd, shclk, done_flag;

    always #(CLK_NS/2) clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ninth_bit(ninth_bit),
        .wr_data(wr_data), .wr_stb(wr_stb), .tick_sync(tick_sync),
        .tick_var(tick_var), .tick_fixed(tick_fixed), .dbl_rate(dbl_rate),
        .done_clr(done_clr), .txd(txd), .shclk(shclk), .done_flag(done_flag)
    );

    // Behavioural model: a queue of {txd, shclk} levels, one entry per bit slot
    bit         m_busy = 1'b0;
    bit         m_done = 1'b0;
    int         m_mode = 0;
    int         m_fcnt = 0;
    logic [1:0] m_q[$];
    string      req_tag = "R1";
    int         checks = 0;
    int         errors = 0;
    int         cyc_no = 0;

    function automatic bit m_bt();
        case (m_mode)
            0:       return tick_sync;
            2:       return tick_fixed && (dbl_rate || ((m_fcnt + 1) % 2 == 0));
            default: return tick_var;
        endcase
    endfunction

    always @(posedge clk) begin
        bit set_now;
        bit b;
        set_now = 1'b0;
        if (!rst_n) begin
            m_busy = 1'b0;
            m_done = 1'b0;
            m_fcnt = 0;
            m_q.delete();
        end else begin
            if (!m_busy) begin
                if (wr_stb) begin
                    m_mode = int'(mode_sel);
                    m_fcnt = 0;
                    m_busy = 1'b1;
                    m_q.delete();
                    if (m_mode == 0) begin
                        for (int i = 0; i < 8; i++) begin
                            m_q.push_back({wr_data[i], 1'b1});
                            m_q.push_back({wr_data[i], 1'b0});
                        end
                    end else begin
                        m_q.push_back(2'b01);
                        for (int i = 0; i < 8; i++) m_q.push_back({wr_data[i], 1'b1});
                        if (m_mode >= 2) m_q.push_back({ninth_bit, 1'b1});
                        m_q.push_back(2'b11);
                    end
                end
            end else begin
                b = m_bt();
                if (m_mode == 2 && tick_fixed) m_fcnt++;
                if (b) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) begin
                        m_busy  = 1'b0;
                        set_now = 1'b1;
                    end
                end
            end
            if (set_now) m_done = 1'b1;
            else if (done_clr) m_done = 1'b0;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc_no);
        end
    endtask

    // One clock: compare at the falling edge, then drive the next inputs
    task automatic cyc();
        logic [1:0] e;
        @(negedge clk);
        e = m_busy ? m_q[0] : 2'b11;
        chk(txd == e[1], req_tag, "txd", int'(txd), int'(e[1]));
        chk(shclk == e[0], req_tag, "shclk", int'(shclk), int'(e[0]));
        chk(done_flag == m_done, req_tag, "done_flag", int'(done_flag), int'(m_done));
        wr_stb   = 1'b0;
        done_clr = 1'b0;
        cyc_no++;
        tick_sync  = (cyc_no % P_SYNC) == 0;
        tick_var   = (cyc_no % P_VAR) == 0;
        tick_fixed = (cyc_no % P_FIX) == 0;
    endtask

    task automatic run_out();
        for (int n = 0; n < 3000 && m_busy; n++) cyc();
    endtask

    task automatic frame(int mode, logic [7:0] d, bit t8, string tag);
        req_tag   = tag;
        mode_sel  = mode[1:0];
        ninth_bit = t8;
        wr_data   = d;
        wr_stb    = 1'b1;
        cyc();
        run_out();
        cyc();
        chk(done_flag == 1'b1, "R6", "done after frame", int'(done_flag), 1);
        done_clr = 1'b1;
        cyc();
        chk(done_flag == 1'b0, "R7", "done cleared", int'(done_flag), 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        chk(txd == 1'b1 && shclk == 1'b1 && done_flag == 1'b0, "R1", "reset lines",
            int'({txd, shclk, done_flag}), 6);
        rst_n = 1'b1;
        repeat (4) cyc();

        // R2 / R10: 8-bit async on tick_var while other ticks also toggle
        frame(1, 8'hA5, 1'b1, "R2");
        frame(1, 8'h01, 1'b0, "R10");
        // R3: 9-bit variable rate, both ninth values
        frame(3, 8'h3C, 1'b1, "R3");
        frame(3, 8'hC3, 1'b0, "R3");
        // R4: fixed rate, slow and doubled
        dbl_rate = 1'b0;
        frame(2, 8'h81, 1'b1, "R4");
        dbl_rate = 1'b1;
        frame(2, 8'h7E, 1'b0, "R4");
        dbl_rate = 1'b0;
        // R5: synchronous shift, ninth input has no effect
        frame(0, 8'h96, 1'b1, "R5");
        frame(0, 8'h69, 1'b0, "R5");

        // R8 / R9: write and input changes in mid-frame
        req_tag = "R8";
        mode_sel = 2'd3; ninth_bit = 1'b1; wr_data = 8'h5A; wr_stb = 1'b1;
        cyc();
        for (int n = 0; n < 40; n++) begin
            if (n == 12) begin
                wr_stb = 1'b1; wr_data = 8'hFF; mode_sel = 2'd0; ninth_bit = 1'b0;
                req_tag = "R9";
            end
            cyc();
        end
        run_out();
        repeat (20) cyc();
        chk(txd == 1'b1 && shclk == 1'b1, "R8", "line idle after frame",
            int'({txd, shclk}), 3);
        chk(done_flag == 1'b1, "R6", "done after disturbed frame", int'(done_flag), 1);

        // R7: clear collides with the frame end; the set must win
        req_tag = "R7";
        mode_sel = 2'd1; wr_data = 8'h33; wr_stb = 1'b1;
        cyc();
        for (int n = 0; n < 3000 && m_busy; n++) begin
            if (m_q.size() == 1 && m_bt()) done_clr = 1'b1;
            cyc();
        end
        cyc();
        chk(done_flag == 1'b1, "R7", "set wins over clear", int'(done_flag), 1);
        repeat (10) cyc();
        chk(done_flag == 1'b1, "R7", "flag held without clear", int'(done_flag), 1);
        done_clr = 1'b1;
        cyc();
        chk(done_flag == 1'b0, "R7", "clear alone", int'(done_flag), 0);

        // R1: back-to-back after reset pulse mid-frame
        req_tag = "R1";
        mode_sel = 2'd0; wr_data = 8'h0F; wr_stb = 1'b1;
        repeat (8) cyc();
        rst_n = 1'b0;
        cyc();
        chk(txd == 1'b1 && shclk == 1'b1 && done_flag == 1'b0, "R1", "reset mid-frame",
            int'({txd, shclk, done_flag}), 6);
        rst_n = 1'b1;
        repeat (4) cyc();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule